// File: doc/BRIEF.md
# Sender Overrun-Buffered Flow Controller

This block lives in the sender clock domain, between a sender core and a request/acknowledge link toward a receiver in another clock domain. Each sender clock, the core may offer one data item with a send strobe. The block keeps a short direct queue that feeds the link. When that queue is full and another item arrives, the block moves a path switch over to a deeper overrun queue. It also raises a pause request toward the sender's clock generator.

The pause does not stop the core at once. A parameterised stall pipeline stands for the clock-distribution latency, so the core keeps running for that many cycles and may keep sending. The overrun queue catches those items. The path switch and the pause request are separate signals. While the switch still routes into the overrun queue, the pause can lift for a single cycle when a slot frees up: either the link acknowledged an item, or the core let an enabled cycle pass without sending. Each such release lets exactly one more core cycle through, after the same latency.

Order is kept across both paths, because the overrun queue always drains into the tail of the direct queue.

Top module: `ovr_flow_ctrl`

## Requirements
- R1: After reset, `tx_valid_o` is 0, `switch_o` is 1 (direct path), `pause_o` is 0 and `core_en_o` is 1.
- R2: An item is taken on a clock edge only when `send_en_i` and `core_en_o` are both 1. A strobe given while `core_en_o` is 0 is dropped and its data never appears on `tx_data_o`.
- R3: The direct queue holds DIR_DEPTH (2) items. While `switch_o` is 1 and the direct queue is not full, a taken item enters it. `tx_valid_o` is 1 whenever the direct queue holds an item.
- R4: On an edge where an item is taken while the direct queue is full, the item enters the overrun queue (OVR_DEPTH = 3 items) and `switch_o` becomes 0. With no acknowledges and a constant strobe from reset, `switch_o` is first seen low after the third item.
- R5: `pause_o` rises on the same edge on which `switch_o` falls.
- R6: `core_en_o` in any cycle equals the inverse of `pause_o` LAT cycles earlier (LAT = 2). With a constant strobe and no acknowledges, exactly 2 + 1 + LAT = 5 items are taken.
- R7: `switch_o` returns to 1 only when the overrun queue is empty, and it is 1 once the link has drained every item.
- R8: While `switch_o` is 0, an acknowledge that frees a slot drops `pause_o` for exactly one cycle. This lets exactly one extra core cycle through LAT cycles later.
- R9: While `switch_o` is 0, an enabled core cycle with `send_en_i` low drops `pause_o` for exactly one cycle, with the same one-cycle effect on `core_en_o`.
- R10: `tx_data_o` and `tx_valid_o` hold while `tx_valid_o` is 1 and `tx_ack_i` is 0. An item leaves on an edge with both high. Items leave in the order they were taken, with none lost or repeated.
- R11: With LAT < OVR_DEPTH, the overrun queue never receives an item while full, for any strobe and acknowledge pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sender buffered clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| send_en_i | input | 1 | Core send strobe for this cycle |
| send_data_i | input | DW | Item offered with the strobe |
| core_en_o | output | 1 | Modelled core clock enable after the stall latency |
| pause_o | output | 1 | Pause request to the clock generator |
| switch_o | output | 1 | Path switch: 1 direct path, 0 overrun path |
| tx_valid_o | output | 1 | Item present toward the receiver |
| tx_data_o | output | DW | Head item of the direct queue |
| tx_ack_i | input | 1 | Receiver acknowledge; removes the head item |

## Verification
The assertions assume the sender honours the modelled stall: items are taken only in cycles where `core_en_o` is high, so the overrun queue cannot be overfilled. The assertions also assume the receiver acknowledges only items that are offered. The stimulus drives the strobe freely, including in stalled cycles, to exercise the drop rule. It only counts acceptance where `core_en_o` was high, and it raises `tx_ack_i` without regard to `tx_valid_o`, since an acknowledge with no valid item is simply not a transfer. The sweep covers every 4-cycle periodic strobe pattern against every non-zero 4-cycle acknowledge pattern. It is followed by directed runs for the switch, stall timing and both release causes.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
  typedef enum logic {
    PATH_OVR = 1'b0,
    PATH_DIR = 1'b1
  } path_e;
endpackage

// File: rtl/ovr_ring_fifo.sv
// Overrun queue: one-hot ring counters for entry and exit, with a lap bit each.
module ovr_ring_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam logic [DEPTH-1:0] RING_INIT = DEPTH'(1);

  logic [DEPTH-1:0] in_ring, out_ring;
  logic             in_lap, out_lap;
  logic [DW-1:0]    slot_q [DEPTH];
  logic             same_pos;

  assign same_pos = (in_ring == out_ring);
  assign empty_o  = same_pos && (in_lap == out_lap);
  assign full_o   = same_pos && (in_lap != out_lap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_ring  <= RING_INIT;
      out_ring <= RING_INIT;
      in_lap   <= 1'b0;
      out_lap  <= 1'b0;
    end else begin
      if (push_i) begin
        in_ring <= {in_ring[DEPTH-2:0], in_ring[DEPTH-1]};
        if (in_ring[DEPTH-1]) in_lap <= ~in_lap;
      end
      if (pop_i) begin
        out_ring <= {out_ring[DEPTH-2:0], out_ring[DEPTH-1]};
        if (out_ring[DEPTH-1]) out_lap <= ~out_lap;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && in_ring[g]) slot_q[g] <= din_i;
    end
  end

  always_comb begin
    dout_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (out_ring[k]) dout_o = dout_o | slot_q[k];
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_ring_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(in_ring) == 1) && ($countones(out_ring) == 1));
endmodule

// File: rtl/ovr_dir_fifo.sv
// Direct queue toward the link; head is the offered item.
module ovr_dir_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (fill == '0);
  assign full_o  = (fill == CW'(DEPTH));
  assign dout_o  = mem_q[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_i) wr_ptr <= step_ptr(wr_ptr);
      if (pop_i)  rd_ptr <= step_ptr(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr] <= din_i;
  end

  p_dir_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_dir_no_underflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ovr_stall_pipe.sv
// Models pause-to-stall latency of the sender clock tree.
module ovr_stall_pipe #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pause_i,
  output logic stall_o
);
  logic [LAT-1:0] pipe_q;

  if (LAT == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= pause_i;
    end
  end else begin : g_shift
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= {pipe_q[LAT-2:0], pause_i};
    end
  end

  assign stall_o = pipe_q[LAT-1];

  p_stall_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(pipe_q != '0));
endmodule

// File: rtl/ovr_flow_ctrl.sv
module ovr_flow_ctrl
  import ovr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DIR_DEPTH = 2,
  parameter int OVR_DEPTH = 3,
  parameter int LAT       = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          send_en_i,
  input  logic [DW-1:0] send_data_i,
  output logic          core_en_o,
  output logic          pause_o,
  output logic          switch_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ack_i
);
  path_e         sw_q, sw_d;
  logic          pause_q, pause_d;
  logic          stall, take, pop, dir_space, direct_mode;
  logic          core_to_dir, core_to_ovr, xfer, slot_free;
  logic          dir_push, dir_empty, dir_full;
  logic          ovr_empty, ovr_full;
  logic [DW-1:0] dir_din, ovr_dout;

  ovr_stall_pipe #(.LAT(LAT)) u_stall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pause_i(pause_q),
    .stall_o(stall)
  );

  assign core_en_o   = ~stall;
  assign take        = send_en_i & core_en_o;
  assign tx_valid_o  = ~dir_empty;
  assign pop         = tx_valid_o & tx_ack_i;
  assign dir_space   = ~dir_full | pop;
  // Overrun drained: behave as direct even before switch re-registers.
  assign direct_mode = (sw_q == PATH_DIR) | ovr_empty;
  assign core_to_dir = take & direct_mode & ~dir_full;
  assign core_to_ovr = take & ~core_to_dir;
  assign xfer        = ~ovr_empty & dir_space;
  assign dir_push    = core_to_dir | xfer;
  assign dir_din     = xfer ? ovr_dout : send_data_i;

  ovr_ring_fifo #(.DW(DW), .DEPTH(OVR_DEPTH)) u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (core_to_ovr),
    .din_i  (send_data_i),
    .pop_i  (xfer),
    .dout_o (ovr_dout),
    .empty_o(ovr_empty),
    .full_o (ovr_full)
  );

  ovr_dir_fifo #(.DW(DW), .DEPTH(DIR_DEPTH)) u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (dir_push),
    .din_i  (dir_din),
    .pop_i  (pop),
    .dout_o (tx_data_o),
    .empty_o(dir_empty),
    .full_o (dir_full)
  );

  // One release per freed slot: ack that drains an overrun item, or idle enabled cycle.
  assign slot_free = (pop & ~ovr_empty) | (core_en_o & ~send_en_i);

  always_comb begin
    if (direct_mode) sw_d = (take & dir_full) ? PATH_OVR : PATH_DIR;
    else             sw_d = PATH_OVR;
    pause_d = (sw_d == PATH_OVR) & ~((sw_q == PATH_OVR) & slot_free);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q    <= PATH_DIR;
      pause_q <= 1'b0;
    end else begin
      sw_q    <= sw_d;
      pause_q <= pause_d;
    end
  end

  assign switch_o = (sw_q == PATH_DIR);
  assign pause_o  = pause_q;

  p_pause_on_switch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(switch_o) |-> pause_o);
  p_switch_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_o |-> ovr_empty);
  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ack_i) |=> (tx_valid_o && $stable(tx_data_o)));
  p_single_source_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_to_dir && xfer));
  p_ovr_full_switch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_full |-> !switch_o);
endmodule

// File: tb/tb_ovr_flow_ctrl.sv
module tb_ovr_flow_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          send_en_i = 1'b0;
  logic [DW-1:0] send_data_i = '0;
  logic          core_en_o, pause_o, switch_o, tx_valid_o, tx_ack_i;
  logic [DW-1:0] tx_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] expq [256];
  int wr_i, rd_i, n_acc, n_rx;
  logic [DW-1:0] seq;
  logic s_sw, s_pause, s_cen, s_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial tx_ack_i = 1'b0;

  ovr_flow_ctrl #(.DW(DW), .DIR_DEPTH(2), .OVR_DEPTH(3), .LAT(LAT)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .send_en_i  (send_en_i),
    .send_data_i(send_data_i),
    .core_en_o  (core_en_o),
    .pause_o    (pause_o),
    .switch_o   (switch_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_ack_i   (tx_ack_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; send_en_i = 1'b0; tx_ack_i = 1'b0; send_data_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    wr_i = 0; rd_i = 0; n_acc = 0; n_rx = 0; seq = '0;
    chk(!tx_valid_o && switch_o && !pause_o && core_en_o, "R1 reset state",
        {tx_valid_o, switch_o, pause_o, core_en_o}, 4'b0101);
  endtask

  // Sample outputs away from the edge, then drive inputs for the next edge.
  task automatic step(input logic snd, input logic ack);
    logic accepted;
    @(negedge clk);
    s_sw = switch_o; s_pause = pause_o; s_cen = core_en_o; s_val = tx_valid_o;
    accepted = snd && core_en_o;
    if (ack && tx_valid_o) begin
      if (rd_i < wr_i)
        chk(tx_data_o == expq[rd_i[7:0]], "R10 R2 order/drop", tx_data_o, expq[rd_i[7:0]]);
      else
        chk(1'b0, "R10 extra item", tx_data_o, -1);
      rd_i++; n_rx++;
    end
    send_en_i = snd;
    send_data_i = accepted ? seq : 8'hFF;
    if (accepted) begin
      expq[wr_i[7:0]] = seq;
      wr_i++; n_acc++; seq = seq + 8'd1;
    end
    tx_ack_i = ack;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1);
    chk(n_rx == n_acc, {tag, " R11 no loss"}, n_rx, n_acc);
    chk(s_sw && !s_pause, {tag, " R7 switch back"}, {s_sw, s_pause}, 2'b10);
  endtask

  initial begin
    int sw_at, p_at, c_at, cnt;
    do_reset();

    // Constant strobe, no acks: switch, pause, latency
    sw_at = -1; p_at = -1; c_at = -1;
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 1'b0);
      if (i == 1) chk(s_val, "R3 valid after first item", s_val, 1);
      if (!s_sw && sw_at < 0) sw_at = i;
      if (s_pause && p_at < 0) p_at = i;
      if (!s_cen && c_at < 0) c_at = i;
    end
    chk(sw_at == 3, "R4 switch after third item", sw_at, 3);
    chk(p_at == sw_at, "R5 pause with switch", p_at, sw_at);
    chk(c_at - p_at == LAT, "R6 stall latency", c_at - p_at, LAT);
    chk(n_acc == 3 + LAT, "R6 R11 items taken", n_acc, 3 + LAT);

    // Ack release
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk(!s_pause && !s_sw, "R8 pause dropped on ack", {s_sw, s_pause}, 2'b00);
    cnt = s_cen ? 1 : 0;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b0);
      if (i == 0) chk(s_pause, "R8 single-cycle release", s_pause, 1);
      if (s_cen) cnt++;
    end
    chk(cnt == 1, "R8 one extra core cycle", cnt, 1);
    chk(n_acc == 4 + LAT, "R8 items taken", n_acc, 4 + LAT);
    drain("R8");

    // Idle release
    do_reset();
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      step((i == 4) ? 1'b0 : 1'b1, 1'b0);
      if (i >= 3 && !s_sw && !s_pause) cnt++;
      if (i == 5) chk(!s_pause && !s_sw, "R9 pause dropped on idle", {s_sw, s_pause}, 2'b00);
    end
    chk(cnt == 1, "R9 one release cycle", cnt, 1);
    chk(n_acc == 5, "R9 items taken", n_acc, 5);
    drain("R9");

    // Sweep all periodic strobe vs ack patterns
    for (int s = 0; s < 16; s++) begin
      for (int a = 1; a < 16; a++) begin
        do_reset();
        for (int i = 0; i < 40; i++) step(s[i % 4], a[i % 4]);
        drain("R10 sweep");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000 && !done) begin
        done = 1;
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 200000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end
endmodule